// File: doc/BRIEF.md
# Per-Bit Programmable Edge Detector Array

This block watches a wide parallel trace bus and reports, for every bit, when the bit changes in a way that bit has been configured to report. Each bus bit has a 2-bit mode code that selects rising-edge, falling-edge or both-edge (toggle) detection, or turns detection off. The codes are packed sixteen to a 32-bit control register. A separate bank of 32-bit mask registers can exclude any bit from reporting.

Software programs both banks through a small register port. The address map has room for the largest bank sizes. An instance that builds fewer registers treats the unused slots as reserved: writes to them are silently dropped and reads from them return zero. The block compares each bus sample with the previous one. It registers the per-bit event vector and a summary strobe, and both appear one clock after the sample that carries the edge.

Top module: `edge_detect_array`

## Requirements
- R1: Mode code 2'b00 flags a bit whose sample goes from 0 to 1 between two consecutive clocks.
- R2: Mode code 2'b01 flags a bit whose sample goes from 1 to 0 between two consecutive clocks.
- R3: Mode code 2'b10 flags a bit on any change of its sample, in either direction.
- R4: Mode code 2'b11 is reserved, and a bit with that code never raises an event.
- R5: The mode of bus bit i is held in control register i/16, at bits [2*(i%16)+1 : 2*(i%16)]. Bits that are configured with different codes behave independently.
- R6: Bus bit i is controlled by mask register i/32, bit i%32. A mask bit of 1 suppresses every event on that bus bit. A mask bit of 0 lets the configured detection through.
- R7: Control register n is at address n (0 to 15) and mask register n is at address 16+n (16 to 23). A built register reads back the value last written to it. Read data appears on the clock after the read request.
- R8: Addresses of registers that are not built, and addresses 24 to 31, are reserved. Writes to them change no register and no detection behaviour, and reads from them return zero.
- R9: Reset clears every register to zero, which gives rising-edge detection on all bits with nothing masked. Reset also clears the event outputs and the read data.
- R10: The first bus sample taken after reset produces no event, whatever its value.
- R11: An edge between the samples taken at clocks k-1 and k is shown on the event outputs after clock k and not before. The any-event strobe is the OR of the event vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | 5 | Register slot address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| trace_in | input | DATA_W | Monitored bus |
| edge_hit | output | DATA_W | Per-bit event vector, registered |
| edge_any | output | 1 | High when any bit of edge_hit is set |

## Verification
Every mode code is applied to all bits together, under a pseudo-random bus sequence that includes all-zero and all-one steps. This separates the rising, falling, toggle and off behaviours, and shows whether any of them leaks into another. A mixed control pattern then places every code on neighbouring fields, which exposes errors in the field-to-bit mapping. A sparse mask, followed by a walk of a single unmasked bit, shows whether the mask is applied on the right bit. Flooding every reserved slot with ones and then reading back, and running the bus again, shows that reserved accesses leave the live registers untouched. Held samples and a check just before each edge confirm the one-cycle output timing.

// File: rtl/edge_detect_pkg.sv
package edge_detect_pkg;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 5;
  localparam int FIELD_W   = 2;
  localparam int MAX_CTRL  = 16;
  localparam int MAX_MASK  = 8;
  localparam int CTRL_BASE = 0;
  localparam int MASK_BASE = 16;
  localparam int FIELDS_PER_REG = REG_W / FIELD_W;

  typedef enum logic [FIELD_W-1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/edge_bit_cell.sv
module edge_bit_cell
  import edge_detect_pkg::*;
(
  input  logic               cur_i,
  input  logic               prev_i,
  input  logic               armed_i,
  input  logic [FIELD_W-1:0] mode_i,
  input  logic               mask_i,
  output logic               hit_o
);
  logic rise, fall;

  assign rise = cur_i & ~prev_i;
  assign fall = ~cur_i & prev_i;

  always_comb begin
    hit_o = 1'b0;
    if (armed_i && !mask_i) begin
      unique case (edge_mode_e'(mode_i))
        EDGE_RISE: hit_o = rise;
        EDGE_FALL: hit_o = fall;
        EDGE_BOTH: hit_o = rise | fall;
        EDGE_OFF:  hit_o = 1'b0;
        default:   hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/edge_cfg_regs.sv
module edge_cfg_regs
  import edge_detect_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_CTRL = (DATA_W + FIELDS_PER_REG - 1) / FIELDS_PER_REG,
  parameter int NUM_MASK = (DATA_W + REG_W - 1) / REG_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic [REG_W-1:0]      rdata_o,
  output logic [2*DATA_W-1:0]   mode_o,
  output logic [DATA_W-1:0]     mask_o
);
  localparam int CTRL_BITS = NUM_CTRL * REG_W;
  localparam int MASK_BITS = NUM_MASK * REG_W;

  logic [REG_W-1:0]     ctrl_q [NUM_CTRL];
  logic [REG_W-1:0]     mask_q [NUM_MASK];
  logic [CTRL_BITS-1:0] ctrl_cat;
  logic [MASK_BITS-1:0] mask_cat;
  logic [REG_W-1:0]     rd_next;
  logic                 addr_live;

  // Decode: does the address name a register this instance builds?
  always_comb begin
    addr_live = 1'b0;
    for (int k = 0; k < NUM_CTRL; k++)
      if (addr_i == ADDR_W'(CTRL_BASE + k)) addr_live = 1'b1;
    for (int k = 0; k < NUM_MASK; k++)
      if (addr_i == ADDR_W'(MASK_BASE + k)) addr_live = 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CTRL; g++) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (rst)
          ctrl_q[g] <= '0;
        else if (wr_en_i && addr_i == ADDR_W'(CTRL_BASE + g))
          ctrl_q[g] <= wdata_i;
      end
      assign ctrl_cat[g*REG_W +: REG_W] = ctrl_q[g];
    end
    for (g = 0; g < NUM_MASK; g++) begin : g_mask
      always_ff @(posedge clk) begin
        if (rst)
          mask_q[g] <= '0;
        else if (wr_en_i && addr_i == ADDR_W'(MASK_BASE + g))
          mask_q[g] <= wdata_i;
      end
      assign mask_cat[g*REG_W +: REG_W] = mask_q[g];
    end
  endgenerate

  assign mode_o = ctrl_cat[2*DATA_W-1:0];
  assign mask_o = mask_cat[DATA_W-1:0];

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NUM_CTRL; k++)
      if (addr_i == ADDR_W'(CTRL_BASE + k)) rd_next = ctrl_q[k];
    for (int k = 0; k < NUM_MASK; k++)
      if (addr_i == ADDR_W'(MASK_BASE + k)) rd_next = mask_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_o <= '0;
    else if (rd_en_i)
      rdata_o <= rd_next;
  end

  // R8: a write to a reserved slot leaves both banks untouched
  assert_reserved_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !addr_live) |=> ($stable(ctrl_cat) && $stable(mask_cat)));

  // R8: a read of a reserved slot returns zero
  assert_reserved_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !addr_live) |=> (rdata_o == '0));
endmodule

// File: rtl/edge_detect_core.sv
module edge_detect_core
  import edge_detect_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   trace_i,
  input  logic [2*DATA_W-1:0] mode_i,
  input  logic [DATA_W-1:0]   mask_i,
  output logic [DATA_W-1:0]   event_o,
  output logic                any_o
);
  logic [DATA_W-1:0] prev_q;
  logic              armed_q;
  logic [DATA_W-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_bit
      edge_bit_cell u_cell (
        .cur_i   (trace_i[g]),
        .prev_i  (prev_q[g]),
        .armed_i (armed_q),
        .mode_i  (mode_i[FIELD_W*g +: FIELD_W]),
        .mask_i  (mask_i[g]),
        .hit_o   (hit[g])
      );

      // R4: the reserved code keeps the bit silent
      assert_reserved_code_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_i[FIELD_W*g +: FIELD_W] == 2'b11) |=> !event_o[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
      event_o <= '0;
      any_o   <= 1'b0;
    end else begin
      prev_q  <= trace_i;
      armed_q <= 1'b1;
      event_o <= hit;
      any_o   <= |hit;
    end
  end

  // R10: no event for the first sample after reset
  assert_first_sample_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> (event_o == '0));

  // R6: masked bits never report
  assert_masked_silent_R6: assert property (@(posedge clk) disable iff (rst)
    ((event_o & $past(mask_i)) == '0));

  // R11: strobe agrees with the vector
  assert_any_matches_R11: assert property (@(posedge clk) disable iff (rst)
    any_o == (|event_o));
endmodule

// File: rtl/edge_detect_array.sv
module edge_detect_array
  import edge_detect_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_CTRL = (DATA_W + FIELDS_PER_REG - 1) / FIELDS_PER_REG,
  parameter int NUM_MASK = (DATA_W + REG_W - 1) / REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [4:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [DATA_W-1:0] trace_in,
  output logic [DATA_W-1:0] edge_hit,
  output logic              edge_any
);
  logic [2*DATA_W-1:0] mode_w;
  logic [DATA_W-1:0]   mask_w;

  edge_cfg_regs #(
    .DATA_W   (DATA_W),
    .NUM_CTRL (NUM_CTRL),
    .NUM_MASK (NUM_MASK)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (cfg_wr_en),
    .rd_en_i (cfg_rd_en),
    .addr_i  (cfg_addr),
    .wdata_i (cfg_wdata),
    .rdata_o (cfg_rdata),
    .mode_o  (mode_w),
    .mask_o  (mask_w)
  );

  edge_detect_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .trace_i (trace_in),
    .mode_i  (mode_w),
    .mask_i  (mask_w),
    .event_o (edge_hit),
    .any_o   (edge_any)
  );
endmodule

// File: tb/edge_detect_array_tb.sv
module edge_detect_array_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_rd_en = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [W-1:0] trace_in = '0;
  logic [W-1:0] edge_hit;
  logic        edge_any;

  int n_checks = 0;
  int n_fails  = 0;

  // bench model state
  logic [31:0]  m_ctrl [2];
  logic [31:0]  m_mask;
  logic [W-1:0] m_prev;
  logic         m_armed;
  logic [W-1:0] last_exp;
  logic [31:0]  lfsr = 32'h2468_ACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_detect_array #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .trace_in(trace_in), .edge_hit(edge_hit), .edge_any(edge_any)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_hits(input logic [W-1:0] cur);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) begin
      logic [1:0] code = m_ctrl[i/16][2*(i%16) +: 2];
      logic rise = cur[i] & ~m_prev[i];
      logic fall = ~cur[i] & m_prev[i];
      if (m_armed && !m_mask[i]) begin
        case (code)
          2'b00: r[i] = rise;
          2'b01: r[i] = fall;
          2'b10: r[i] = rise | fall;
          default: r[i] = 1'b0;
        endcase
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic apply_sample(input logic [W-1:0] v, input string req);
    logic [W-1:0] exp;
    trace_in = v;
    #1;
    check("R11 pre-edge", edge_hit, last_exp);
    @(negedge clk);
    exp = model_hits(v);
    check(req, edge_hit, exp);
    check({req, " any R11"}, {31'b0, edge_any}, {31'b0, |exp});
    m_prev = v;
    m_armed = 1'b1;
    last_exp = exp;
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (a < 5'd2) m_ctrl[a] = d;
    else if (a == 5'd16) m_mask = d;
    last_exp = '0;
  endtask

  task automatic reg_read(input logic [4:0] a, input logic [31:0] exp, input string req);
    cfg_rd_en = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd_en = 1'b0;
    check(req, cfg_rdata, exp);
    last_exp = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; trace_in = '0;
    repeat (3) @(negedge clk);
    check("R9 reset hit", edge_hit, '0);
    check("R9 reset any", {31'b0, edge_any}, 32'h0);
    check("R9 reset rdata", cfg_rdata, 32'h0);
    rst = 1'b0;
    m_ctrl[0] = '0; m_ctrl[1] = '0; m_mask = '0;
    m_prev = '0; m_armed = 1'b0; last_exp = '0;
  endtask

  task automatic run_rand(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      lfsr = next_rand(lfsr);
      apply_sample(lfsr, req);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    do_reset();
    // R10: first sample after reset, all ones, must be quiet
    apply_sample('1, "R10");
    for (int a = 0; a < 32; a++) reg_read(5'(a), 32'h0, "R9 reset regs");
    // R9 default config: rising everywhere
    apply_sample('0, "R9 default");
    apply_sample('1, "R9 default");

    // R1..R4: one code applied to every bit
    for (int m = 0; m < 4; m++) begin
      string req;
      case (m)
        0: req = "R1";
        1: req = "R2";
        2: req = "R3";
        default: req = "R4";
      endcase
      reg_write(5'd0, {16{2'(m)}});
      reg_write(5'd1, {16{2'(m)}});
      reg_write(5'd16, 32'h0);
      apply_sample('0, req);
      apply_sample('1, req);
      apply_sample('1, req);
      apply_sample('0, req);
      run_rand(40, req);
    end

    // R5: mixed codes on neighbouring fields
    reg_write(5'd0, 32'h1B1B_E4E4);
    reg_write(5'd1, 32'h9C63_2D78);
    apply_sample('0, "R5");
    apply_sample('1, "R5");
    apply_sample('0, "R5");
    run_rand(40, "R5");

    // R6: mask with toggle everywhere
    reg_write(5'd0, 32'hAAAA_AAAA);
    reg_write(5'd1, 32'hAAAA_AAAA);
    reg_write(5'd16, 32'hA5A5_0F0F);
    run_rand(30, "R6");
    for (int k = 0; k < W; k++) begin
      reg_write(5'd16, ~(32'h1 << k));
      apply_sample(~trace_in, "R6 walk");
    end

    // R7: readback of built registers
    reg_write(5'd0, 32'h1234_5678);
    reg_write(5'd1, 32'h9ABC_DEF0);
    reg_write(5'd16, 32'h0F0F_F0F0);
    reg_read(5'd0, 32'h1234_5678, "R7");
    reg_read(5'd1, 32'h9ABC_DEF0, "R7");
    reg_read(5'd16, 32'h0F0F_F0F0, "R7");

    // R8: reserved slots
    for (int a = 2; a < 32; a++)
      if (a != 16) reg_write(5'(a), 32'hFFFF_FFFF);
    for (int a = 2; a < 32; a++)
      if (a != 16) reg_read(5'(a), 32'h0, "R8 reserved read");
    reg_read(5'd0, 32'h1234_5678, "R8 live kept");
    reg_read(5'd1, 32'h9ABC_DEF0, "R8 live kept");
    reg_read(5'd16, 32'h0F0F_F0F0, "R8 live kept");
    run_rand(20, "R8 behaviour");

    // R9: reset mid-run clears configuration
    @(negedge clk);
    do_reset();
    apply_sample(32'h5555_AAAA, "R10 second");
    reg_read(5'd0, 32'h0, "R9 after reset");
    reg_read(5'd1, 32'h0, "R9 after reset");
    reg_read(5'd16, 32'h0, "R9 after reset");
    run_rand(10, "R9 default");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule